// File: doc/BRIEF.md
# Complement-Alternating Pattern Generator

This block produces a parallel test pattern that changes at a fixed, programmable step rate. At each step the new pattern is the bitwise inverse of the present one, and one is added to that inverse whenever the present pattern has its top bit set. The carry out of the top bit is dropped, so the value always stays WIDTH bits wide. Starting from a low value, the output alternates between a slowly rising low number and its mirrored high number. This toggles far more bits per step than a binary counter, which makes it useful as a pin or bus stimulus source.

Everything runs on one system clock. An internal modulo-N divider issues a single-cycle step strobe, and the pattern register only moves on that strobe. A synchronous reset restores a seed value. A load port overwrites the pattern at any time, and a run-enable input pauses both the divider and the pattern.

Top module: `cpg_pattern_gen`

## Requirements
- R1: One clock edge with `rst` high sets `pattern` to the SEED parameter (default 125) and clears the divider phase.
- R2: On a step, a pattern whose top bit (bit WIDTH-1) is 0 is replaced by its bitwise inverse.
- R3: On a step, a pattern whose top bit is 1 is replaced by its bitwise inverse plus one, taken modulo 2^WIDTH. So 65535 goes to 1, and 32768 goes to itself.
- R4: With `run_en` held high, a step happens once every DIV_RATIO (default 16) clock cycles. The first step lands on the DIV_RATIO-th rising edge after `rst` goes low. Between steps `pattern` does not change.
- R5: While `run_en` is low, neither `pattern` nor the divider phase advances. After `run_en` returns high, counting resumes from the phase where it stopped.
- R6: `load_en` high at an edge writes `load_data` into `pattern`. This takes priority over a step in the same cycle, works whether `run_en` is high or low, and leaves the divider phase untouched.
- R7: From the default seed, the first five stepped outputs are 125, 65410, 126, 65409 and 127.
- R8: For a value x below 2^(WIDTH-1), two consecutive steps produce x+1. Apart from the fixed point 2^(WIDTH-1), no stepped output ever equals the output from two steps earlier, so the sequence cannot lock onto two values.
- R9: `rst` takes priority over `load_en` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | High lets the divider and the pattern advance |
| load_en | input | 1 | High writes `load_data` into the pattern at the next edge |
| load_data | input | WIDTH | Value written into the pattern on load |
| pattern | output | WIDTH | Current pattern value |

## Verification
The bench loads values on both sides of the half-scale boundary and checks the value after one step:
- 0 must become all ones.
- All ones must wrap to 1 without widening.
- 32768 must stay fixed.
- 32767 must move to 32768.

A design that added one on both halves, or on neither, fails these checks, and it also trips the two-step lock-up monitor. A design that adds one on neither half fails the R8 check that a low value comes back one larger. The bench times the first step after reset to catch an off-by-one divider. It asserts a load exactly on a strobe cycle to catch a step that wins over a load. It drops `run_en` mid-phase to catch a divider that keeps counting while the pattern is paused.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

  // What the pattern register does at the next clock edge
  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_STEP = 2'd1,
    UPD_LOAD = 2'd2,
    UPD_SEED = 2'd3
  } cpg_upd_e;

endpackage

// File: rtl/cpg_divider.sv
module cpg_divider #(
  parameter int DIV_RATIO = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  output logic step
);

  localparam int CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

  logic [CW-1:0] phase_q;
  logic          at_last;

  generate
    if (DIV_RATIO > 1) begin : g_count
      assign at_last = (phase_q == LAST);

      always_ff @(posedge clk) begin
        if (rst) begin
          phase_q <= '0;
        end else if (run_en) begin
          if (at_last) phase_q <= '0;
          else         phase_q <= phase_q + CW'(1);
        end
      end

      // R4: a strobe is never followed by another one on the next cycle
      p_strobe_gap_r4: assert property (@(posedge clk) disable iff (rst)
        step |=> !step);
    end else begin : g_every
      assign at_last = 1'b1;

      always_ff @(posedge clk) begin
        phase_q <= '0;
      end
    end
  endgenerate

  assign step = run_en && at_last;

  // R5: the strobe only fires while running
  p_strobe_needs_run_r5: assert property (@(posedge clk) disable iff (rst)
    step |-> run_en);

  // R5: the phase stays where it is while paused
  p_phase_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> $stable(phase_q));

  // R1: the phase starts at zero after reset
  p_phase_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> phase_q == '0);

endmodule

// File: rtl/cpg_pattern_reg.sv
module cpg_pattern_reg
  import cpg_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter logic [WIDTH-1:0] SEED = WIDTH'(125)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_data,
  output logic [WIDTH-1:0] value
);

  localparam int TOP = WIDTH - 1;
  localparam logic [WIDTH-1:0] HALF = {1'b1, {(WIDTH-1){1'b0}}};

  // Inverse plus the top bit; the sum is cut back to WIDTH bits
  function automatic logic [WIDTH-1:0] mirror_step(input logic [WIDTH-1:0] cur);
    logic [WIDTH:0] wide;
    wide = {1'b0, ~cur} + {{WIDTH{1'b0}}, cur[TOP]};
    return wide[WIDTH-1:0];
  endfunction

  logic [WIDTH-1:0] value_q;
  logic [WIDTH-1:0] next_val;
  logic             msb_now;
  cpg_upd_e         upd_kind;

  assign msb_now  = value_q[TOP];
  assign next_val = mirror_step(value_q);

  always_comb begin
    if (rst)          upd_kind = UPD_SEED;
    else if (load_en) upd_kind = UPD_LOAD;
    else if (step)    upd_kind = UPD_STEP;
    else              upd_kind = UPD_HOLD;
  end

  always_ff @(posedge clk) begin
    unique case (upd_kind)
      UPD_SEED: value_q <= SEED;
      UPD_LOAD: value_q <= load_data;
      UPD_STEP: value_q <= next_val;
      default:  value_q <= value_q;
    endcase
  end

  assign value = value_q;

  // R1: the seed appears right after reset
  p_reset_seed_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> value_q == SEED);

  // R6: a load wins and lands on the next edge
  p_load_wins_r6: assert property (@(posedge clk) disable iff (rst)
    load_en |=> value_q == $past(load_data));

  // R4: without a strobe or a load the value holds
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!step && !load_en) |=> $stable(value_q));

  // R2: a low value always steps to a value with the top bit set
  p_low_goes_high_r2: assert property (@(posedge clk) disable iff (rst)
    (step && !load_en && !msb_now) |=> value_q[TOP]);

  // R3: a high value other than half scale steps to a low value
  p_high_goes_low_r3: assert property (@(posedge clk) disable iff (rst)
    (step && !load_en && msb_now && value_q != HALF) |=> !value_q[TOP]);

  // R3: half scale is a fixed point of the step
  p_half_fixed_r3: assert property (@(posedge clk) disable iff (rst)
    (step && !load_en && value_q == HALF) |=> value_q == HALF);

endmodule

// File: rtl/cpg_pattern_gen.sv
module cpg_pattern_gen #(
  parameter int WIDTH     = 16,
  parameter int DIV_RATIO = 16,
  parameter logic [WIDTH-1:0] SEED = WIDTH'(125)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_data,
  output logic [WIDTH-1:0] pattern
);

  logic step_strobe;

  cpg_divider #(
    .DIV_RATIO (DIV_RATIO)
  ) u_div (
    .clk    (clk),
    .rst    (rst),
    .run_en (run_en),
    .step   (step_strobe)
  );

  cpg_pattern_reg #(
    .WIDTH (WIDTH),
    .SEED  (SEED)
  ) u_reg (
    .clk       (clk),
    .rst       (rst),
    .step      (step_strobe),
    .load_en   (load_en),
    .load_data (load_data),
    .value     (pattern)
  );

  // R5: paused and not loading means the output holds
  p_pause_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !load_en) |=> $stable(pattern));

  // R9: reset overrides a simultaneous load
  p_reset_over_load_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && $past(load_en)) |-> pattern == SEED);

endmodule

// File: tb/cpg_pattern_gen_bench.sv
module cpg_pattern_gen_bench;

  localparam int W = 16;
  localparam int N = 16;
  localparam logic [W-1:0] SEED = 16'd125;
  localparam logic [W-1:0] HALF = 16'h8000;

  localparam int NV = 8;
  localparam logic [W-1:0] VEC_IN  [NV] = '{16'd125, 16'd65410, 16'd0, 16'd65535,
                                            16'd32768, 16'd32767, 16'd1, 16'd65534};
  localparam logic [W-1:0] VEC_OUT [NV] = '{16'd65410, 16'd126, 16'd65535, 16'd1,
                                            16'd32768, 16'd32768, 16'd65534, 16'd2};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0;
  logic load_en = 1'b0;
  logic [W-1:0] load_data = '0;
  logic [W-1:0] pattern;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cpg_pattern_gen #(.WIDTH(W), .DIV_RATIO(N), .SEED(SEED)) u_cpg_pattern_gen (
    .clk(clk), .rst(rst), .run_en(run_en), .load_en(load_en),
    .load_data(load_data), .pattern(pattern)
  );

  // Reference: full scale minus value, plus one at or above half scale
  function automatic logic [W-1:0] ref_next(input logic [W-1:0] p);
    int r;
    r = 65535 - int'(p) + ((int'(p) >= 32768) ? 1 : 0);
    return W'(r % 65536);
  endfunction

  // Model of step timing and value
  int ph = 0;
  logic [W-1:0] ref_val = SEED;
  logic model_step;
  logic just_stepped = 1'b0;
  assign model_step = run_en && (ph == N - 1);

  always @(posedge clk) begin
    if (rst) begin
      ph <= 0;
      ref_val <= SEED;
      just_stepped <= 1'b0;
    end else begin
      if (run_en) ph <= (ph == N - 1) ? 0 : ph + 1;
      if (load_en) ref_val <= load_data;
      else if (model_step) ref_val <= ref_next(ref_val);
      just_stepped <= model_step && !load_en;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Continuous comparison and lock-up monitor (R2, R3, R8)
  logic [W-1:0] h1, h2;
  int hcount = 0;
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R2/R3 model", pattern, ref_val);
      if (load_en) hcount = 0;
      if (just_stepped) begin
        if (hcount >= 2 && pattern == h2 && h1 != pattern) begin
          checks++;
          failures++;
          $display("FAIL R8 lockup act=%0d exp!=%0d", pattern, h2);
        end
        h2 = h1;
        h1 = pattern;
        hcount++;
      end
    end
  end

  task automatic wait_step();
    do @(negedge clk); while (!model_step);
    @(negedge clk);
  endtask

  task automatic do_load(input logic [W-1:0] v);
    load_en = 1'b1;
    load_data = v;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cyc;
    logic [W-1:0] held;
    run_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset seed", pattern, SEED);
    rst = 1'b0;

    // R4: the first step comes after exactly N edges
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (pattern == SEED && cyc < 100);
    chk("R4 first step delay", W'(cyc), W'(N));
    chk("R7 seq 2", pattern, 16'd65410);
    wait_step(); chk("R7 seq 3", pattern, 16'd126);
    wait_step(); chk("R7 seq 4", pattern, 16'd65409);
    wait_step(); chk("R7 seq 5", pattern, 16'd127);

    // Vector table (R2, R3)
    for (int i = 0; i < NV; i++) begin
      do_load(VEC_IN[i]);
      chk("R6 load", pattern, VEC_IN[i]);
      wait_step();
      chk(VEC_IN[i][W-1] ? "R3 high step" : "R2 low step", pattern, VEC_OUT[i]);
    end

    // R8: two steps from a low value give value + 1
    do_load(16'd300);
    wait_step(); wait_step();
    chk("R8 two steps", pattern, 16'd301);

    // R4: the pattern holds between strobes
    held = pattern;
    repeat (N / 2) @(negedge clk);
    if (ph != 0 || !model_step) chk("R4 hold between", pattern, held);

    // R6: a load on a strobe cycle wins
    do @(negedge clk); while (!model_step);
    do_load(16'd4660);
    chk("R6 load over step", pattern, 16'd4660);

    // R5: pausing freezes the pattern and the phase
    repeat (5) @(negedge clk);
    held = pattern;
    run_en = 1'b0;
    repeat (3 * N) @(negedge clk);
    chk("R5 paused value", pattern, held);
    do_load(16'd7);
    chk("R6 load while paused", pattern, 16'd7);
    run_en = 1'b1;
    wait_step();
    chk("R5 resume step", pattern, 16'd65528);

    // R9: reset beats a simultaneous load
    @(negedge clk);
    rst = 1'b1;
    load_en = 1'b1;
    load_data = 16'd999;
    @(negedge clk);
    load_en = 1'b0;
    chk("R9 reset over load", pattern, SEED);
    rst = 1'b0;
    wait_step();
    chk("R1 step after reset", pattern, 16'd65410);

    // Long run to exercise the lock-up monitor (R8)
    do_load(16'd32760);
    repeat (40) wait_step();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule